// File: doc/BRIEF.md
# Buffered Serial Transmitter with Level-Triggered Flags

This block sends bytes as asynchronous serial frames on a single output line. Bytes are written into a 16-entry first-in first-out store. The serializer takes them from there one at a time. Each frame has a low start bit, eight data bits with the least significant bit first, and one or two high stop bits. Every bit period is one pulse of an external baud tick, so the bit rate is set outside the block.

Two status flags let a host keep the store filled without polling it byte by byte.

- **Refill request flag.** It is high whenever the number of held bytes is at or below a threshold picked by a 2-bit field. While that condition lasts, a clear strobe cannot take the flag low.
- **Frame-end flag.** It rises as the stop bit of the final queued byte begins. It does not wait for that stop bit to finish.

The current fill level is reported in the upper byte of a 16-bit count word.

When transmit enable is dropped, the serializer returns to idle at once, wherever it was in a frame. While the transmitter is disabled, a two-bit pin mode together with a pin data bit can force the line to a fixed level. Forcing the line low in this way sends a break.

Top module: `uart_fifo_tx`

## Requirements
- R1: The store holds up to 16 bytes, and a write while it holds 16 is dropped without changing the contents or the count.
- R2: `fifo_count[15:8]` shows the number of bytes held, and `fifo_count[7:0]` reads zero.
- R3: The threshold is 8, 4, 2 or 1 byte for `trig_sel` values 0, 1, 2 and 3. `tdfe` is 1 in the cycle after any cycle in which the level is at or below the threshold.
- R4: A `tdfe_clr` pulse makes `tdfe` 0 on the next cycle only when the level is above the threshold. When the level is at or below it, `tdfe` stays 1.
- R5: Each bit lasts one tick period, and the line changes in the cycle after a tick. A frame is one 0 start bit, then 8 data bits least significant bit first, then one 1 stop bit, or two when `two_stop` is 1. A queued byte starts on the tick right after the last stop bit, with no gap.
- R6: While enabled with nothing queued, `txd` is 1. After the last stop bit, the next tick leaves the line high.
- R7: `tend` rises in the cycle the first stop bit begins if the store is then empty. It stays 0 at the stop bit of a byte that has others queued behind it. It goes to 0 when a frame starts or on a `tend_clr` pulse.
- R8: Dropping `tx_enable` aborts the current frame at once. After re-enabling, a newly written byte is sent as a complete frame starting with its start bit at the next tick.
- R9: While `tx_enable` is 0, `pin_mode` 2'b10 drives `txd` to `pin_data`, and any other mode gives 1. While enabled, the pin override has no effect.
- R10: After reset the count is 0, `tdfe` and `tend` are 1, and the idle line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for a transmit byte |
| wr_data | input | 8 | Byte to queue |
| tx_enable | input | 1 | Transmit enable; 0 resets the serializer |
| trig_sel | input | 2 | Refill threshold select (8, 4, 2, 1) |
| two_stop | input | 1 | 1 selects two stop bits |
| tdfe_clr | input | 1 | Clear strobe for the refill request flag |
| tend_clr | input | 1 | Clear strobe for the frame-end flag |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| pin_mode | input | 2 | Line override mode while disabled (2'b10 forces) |
| pin_data | input | 1 | Forced line level |
| tdfe | output | 1 | Refill request flag |
| tend | output | 1 | Frame-end flag |
| fifo_count | output | 16 | Fill level in bits [15:8] |
| txd | output | 1 | Serial output line |

## Verification
The bench clears the refill flag at every fill level from 0 to 16 under all four thresholds. A flag that only triggered below the threshold, or that a clear could knock down while the level was still low, is caught at the boundary level.

It decodes every line bit after each tick for random byte sequences with one and two stop bits:
- A design that set the frame-end flag at the end of the stop bit would be caught.
- So would one that set it at the stop bit of a byte with more bytes queued behind it.
- A gap between queued frames shows up as a misplaced start bit.

Overfilling the store and then draining it exposes a design that overwrote stored bytes. Dropping enable in the middle of a frame must give the break level at once and then a clean, complete frame; a serializer that resumed from where it stopped would fail this.

// File: rtl/txf_pkg.sv
// Package: shared types and constants for the buffered serial transmitter.
// Assumes one data byte per frame and one tick per bit period.
package txf_pkg;

    // Serializer phase within a frame
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } tx_phase_t;

    // Pin mode value that forces the line to the pin data bit
    localparam logic [1:0] PIN_FORCE = 2'b10;

endpackage

// File: rtl/txf_fifo.sv
// Module: byte store, first-in first-out, with a show-ahead head output.
// Assumes pop is only raised when not empty; a push while full is dropped.
module txf_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  level,
    output logic              empty,
    output logic              full
);

    localparam logic [CNT_W-1:0] LVL_FULL = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic              push_ok;

    assign full    = (level == LVL_FULL);
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign head    = mem[rd_ptr];

    // Store an accepted byte at the write pointer
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance pointers and track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // R1: level never exceeds the depth
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_FULL);

    // R1: a push into a full store without a pop leaves the level unchanged
    assert_drop_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (level == LVL_FULL));

    // R5: the serializer never takes from an empty store
    assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/txf_flags.sv
// Module: refill request and frame-end flags.
// The refill flag is level-driven: it is forced high every cycle the level
// is at or below the selected threshold, so a clear only sticks above it.
// Assumes frame_start and stop_begin come from the serializer as one-cycle events.
module txf_flags #(
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] level,
    input  logic [1:0]       trig_sel,
    input  logic             tdfe_clr,
    input  logic             tend_clr,
    input  logic             stop_begin,
    input  logic             frame_start,
    output logic             tdfe,
    output logic             tend
);

    localparam logic [CNT_W-1:0] TRIG_TOP = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] thresh;
    logic             low_level;
    logic             last_stop;

    assign thresh    = TRIG_TOP >> trig_sel;
    assign low_level = (level <= thresh);
    assign last_stop = stop_begin && (level == '0);

    // Refill request: set by a low level, cleared by strobe otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdfe <= 1'b1;
        end else begin
            tdfe <= (tdfe && !tdfe_clr) || low_level;
        end
    end

    // Frame-end: set at the last stop bit, cleared by a new frame or strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tend <= 1'b1;
        end else if (last_stop) begin
            tend <= 1'b1;
        end else if (frame_start || tend_clr) begin
            tend <= 1'b0;
        end
    end

    // R4: a low level keeps the flag set whatever the clear strobe does
    assert_tdfe_reassert_R4: assert property (@(posedge clk) disable iff (!rst_n)
        low_level |=> tdfe);

    // R7: the frame-end flag only rises at the start of a stop bit
    assert_tend_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_begin |=> (tend == (($past(level) == '0) || ($past(tend) && !$past(tend_clr)))));

endmodule

// File: rtl/txf_serializer.sv
// Module: frame serializer advanced by a one-cycle baud tick.
// Sends start, eight data bits LSB first, then one or two stop bits; takes the
// next byte on the tick that ends the last stop bit. Returns to idle at once
// whenever enable is low.
module txf_serializer
    import txf_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              two_stop,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic              stop_begin,
    output logic              ser_txd
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    tx_phase_t         phase;
    logic [DATA_W-1:0] shreg;
    logic [BIT_W-1:0]  bit_idx;
    logic              stop_idx;
    logic              stop_done;
    logic              step;

    assign step       = enable && tick;
    assign stop_done  = !two_stop || stop_idx;
    assign pop        = step && !fifo_empty &&
                        ((phase == PH_IDLE) || ((phase == PH_STOP) && stop_done));
    assign stop_begin = step && (phase == PH_DATA) && (bit_idx == LAST_BIT);

    // Line level from the current phase
    always_comb begin
        case (phase)
            PH_START: ser_txd = 1'b0;
            PH_DATA:  ser_txd = shreg[0];
            default:  ser_txd = 1'b1;
        endcase
    end

    // Phase sequencing, shifting and bit counting on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            phase    <= PH_IDLE;
            shreg    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
        end else if (tick) begin
            case (phase)
                PH_IDLE: begin
                    if (!fifo_empty) begin
                        shreg <= head;
                        phase <= PH_START;
                    end
                end
                PH_START: begin
                    bit_idx <= '0;
                    phase   <= PH_DATA;
                end
                PH_DATA: begin
                    shreg <= shreg >> 1;
                    if (bit_idx == LAST_BIT) begin
                        stop_idx <= 1'b0;
                        phase    <= PH_STOP;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: begin
                    if (!stop_done) begin
                        stop_idx <= 1'b1;
                    end else if (!fifo_empty) begin
                        shreg <= head;
                        phase <= PH_START;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
            endcase
        end
    end

    // R8: a dropped enable forces the serializer idle on the next cycle
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (phase == PH_IDLE));

    // R5: taking a byte puts a start bit on the line next cycle
    assert_start_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !ser_txd);

    // R5: the stop bit that follows the data is high
    assert_stop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_begin |=> ser_txd);

endmodule

// File: rtl/uart_fifo_tx.sv
// Module: top of the buffered serial transmitter.
// Ties the byte store, the serializer and the flag logic together, exposes the
// fill level in the upper byte of the count word, and applies the line
// override while transmit is disabled.
module uart_fifo_tx
    import txf_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_enable,
    input  logic [1:0]        trig_sel,
    input  logic              two_stop,
    input  logic              tdfe_clr,
    input  logic              tend_clr,
    input  logic              baud_tick,
    input  logic [1:0]        pin_mode,
    input  logic              pin_data,
    output logic              tdfe,
    output logic              tend,
    output logic [15:0]       fifo_count,
    output logic              txd
);

    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  level;
    logic              empty;
    logic              full;
    logic              pop;
    logic              stop_begin;
    logic              ser_txd;

    txf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .level     (level),
        .empty     (empty),
        .full      (full)
    );

    txf_serializer #(.DATA_W(DATA_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (tx_enable),
        .tick       (baud_tick),
        .two_stop   (two_stop),
        .fifo_empty (empty),
        .head       (head),
        .pop        (pop),
        .stop_begin (stop_begin),
        .ser_txd    (ser_txd)
    );

    txf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (level),
        .trig_sel    (trig_sel),
        .tdfe_clr    (tdfe_clr),
        .tend_clr    (tend_clr),
        .stop_begin  (stop_begin),
        .frame_start (pop),
        .tdfe        (tdfe),
        .tend        (tend)
    );

    // Count word: fill level in the upper byte, lower byte unused
    always_comb begin
        fifo_count       = '0;
        fifo_count[15:8] = 8'(level);
    end

    // Line select: serializer when enabled, override or high otherwise
    always_comb begin
        if (tx_enable) begin
            txd = ser_txd;
        end else if (pin_mode == PIN_FORCE) begin
            txd = pin_data;
        end else begin
            txd = 1'b1;
        end
    end

    // R7: the frame-end flag never rises while the line is mid-data
    assert_tend_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && $rose(tend)) |-> txd);

    // R6: an enabled transmitter with nothing queued and no frame keeps the line high
    assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_enable && $past(tx_enable) && empty && $past(empty) && $past(!baud_tick) && $past(txd)) |-> txd);

endmodule

// File: tb/uart_fifo_tx_bench.sv
// Bench: directed corner cases plus seeded random byte streams, checked
// against expected frames and flag values computed here.
module uart_fifo_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        tx_enable;
    logic [1:0]  trig_sel;
    logic        two_stop;
    logic        tdfe_clr;
    logic        tend_clr;
    logic        baud_tick;
    logic [1:0]  pin_mode;
    logic        pin_data;
    logic        tdfe;
    logic        tend;
    logic [15:0] fifo_count;
    logic        txd;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    logic [7:0] bytes [16];

    always #2 clk = ~clk;

    uart_fifo_tx u_uart_fifo_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .tx_enable  (tx_enable),
        .trig_sel   (trig_sel),
        .two_stop   (two_stop),
        .tdfe_clr   (tdfe_clr),
        .tend_clr   (tend_clr),
        .baud_tick  (baud_tick),
        .pin_mode   (pin_mode),
        .pin_data   (pin_data),
        .tdfe       (tdfe),
        .tend       (tend),
        .fifo_count (fifo_count),
        .txd        (txd)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            $display("FAIL watchdog: run exceeded cycle limit (actual %0d expected < 150000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
            $finish;
        end
    end

    function automatic int thresh_of(input logic [1:0] sel);
        return 8 >> sel;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // One tick, then sample line and frame-end flag after the registered update
    task automatic tick_sample(output logic b, output logic te);
        @(negedge clk);
        baud_tick = 1'b1;
        @(negedge clk);
        baud_tick = 1'b0;
        b  = txd;
        te = tend;
        repeat (2) @(negedge clk);
    endtask

    // Tick through n queued frames and compare every bit and the frame-end flag
    task automatic send_and_check(input int n, input logic stops2);
        logic b;
        logic te;
        for (int i = 0; i < n; i++) begin
            tick_sample(b, te);
            check(b == 1'b0, "R5 start bit", b, 0);
            check(te == 1'b0, "R7 tend cleared at frame start", te, 0);
            for (int k = 0; k < 8; k++) begin
                tick_sample(b, te);
                check(b == bytes[i][k], "R5 data bit", b, bytes[i][k]);
            end
            tick_sample(b, te);
            check(b == 1'b1, "R5 stop bit", b, 1);
            check(te == (i == n - 1), "R7 tend at first stop tick", te, (i == n - 1));
            if (stops2) begin
                tick_sample(b, te);
                check(b == 1'b1, "R5 second stop bit", b, 1);
            end
        end
        tick_sample(b, te);
        check(b == 1'b1, "R6 line idle after last frame", b, 1);
    endtask

    initial begin
        logic b;
        logic te;
        int   lvl;
        void'($urandom(32'd1234));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tx_enable = 1'b0;
        trig_sel = 2'd0; two_stop = 1'b0; tdfe_clr = 1'b0; tend_clr = 1'b0;
        baud_tick = 1'b0; pin_mode = 2'b00; pin_data = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(fifo_count == 16'h0000, "R10 count after reset", fifo_count, 0);
        check(tdfe == 1'b1, "R10 tdfe after reset", tdfe, 1);
        check(tend == 1'b1, "R10 tend after reset", tend, 1);
        check(txd == 1'b1, "R10 line after reset", txd, 1);

        // R3/R4: every level 0..16 under every threshold
        for (int n = 0; n <= 16; n++) begin
            if (n > 0) begin
                bytes[n-1] = 8'($urandom);
                write_byte(bytes[n-1]);
            end
            @(negedge clk);
            check(fifo_count[15:8] == 8'(n), "R2 count upper byte", fifo_count[15:8], n);
            check(fifo_count[7:0] == 8'h00, "R2 count lower byte", fifo_count[7:0], 0);
            for (int s = 0; s < 4; s++) begin
                trig_sel = 2'(s);
                @(negedge clk);
                if (n <= thresh_of(2'(s)))
                    check(tdfe == 1'b1, "R3 tdfe at or below threshold", tdfe, 1);
                tdfe_clr = 1'b1;
                @(negedge clk);
                tdfe_clr = 1'b0;
                check(tdfe == (n <= thresh_of(2'(s))), "R4 tdfe after clear", tdfe, (n <= thresh_of(2'(s))));
            end
        end

        // R1: extra writes into a full store are dropped
        for (int j = 0; j < 4; j++) write_byte(8'($urandom));
        @(negedge clk);
        check(fifo_count[15:8] == 8'd16, "R1 full write dropped", fifo_count[15:8], 16);

        // R9: override ignored while enabled
        pin_mode = 2'b10; pin_data = 1'b0;
        @(negedge clk);
        tx_enable = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R9 override ignored when enabled", txd, 1);
        pin_mode = 2'b00; pin_data = 1'b1;

        // R1/R5/R7: drain the first sixteen bytes back to back
        send_and_check(16, 1'b0);
        check(fifo_count[15:8] == 8'd0, "R1 drained count", fifo_count[15:8], 0);

        // R7: clear strobe drops frame-end flag and an idle tick keeps it low
        @(negedge clk);
        tend_clr = 1'b1;
        @(negedge clk);
        tend_clr = 1'b0;
        check(tend == 1'b0, "R7 tend cleared by strobe", tend, 0);
        tick_sample(b, te);
        check(te == 1'b0, "R7 tend stays low on idle tick", te, 0);
        check(b == 1'b1, "R6 idle line enabled", b, 1);

        // R8/R9: abort mid-frame, break level, then a clean frame
        write_byte(8'hFF);
        for (int j = 0; j < 4; j++) tick_sample(b, te);
        check(b == 1'b1, "R5 mid-frame data bit of 0xFF", b, 1);
        @(negedge clk);
        pin_mode = 2'b10; pin_data = 1'b0;
        tx_enable = 1'b0;
        @(negedge clk);
        check(txd == 1'b0, "R9 break forced low", txd, 0);
        pin_data = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R9 forced high", txd, 1);
        pin_data = 1'b0; pin_mode = 2'b01;
        @(negedge clk);
        check(txd == 1'b1, "R9 non-force mode gives high", txd, 1);
        pin_mode = 2'b00;
        tx_enable = 1'b1;
        @(negedge clk);
        check(txd == 1'b1, "R8 idle after re-enable", txd, 1);
        bytes[0] = 8'h5A;
        write_byte(bytes[0]);
        send_and_check(1, 1'b0);

        // R5/R7: seeded random streams with one or two stop bits
        for (int r = 0; r < 8; r++) begin
            lvl = 1 + int'($urandom % 8);
            two_stop = 1'($urandom);
            for (int j = 0; j < lvl; j++) begin
                bytes[j] = 8'($urandom);
                write_byte(bytes[j]);
            end
            send_and_check(lvl, two_stop);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule